// File: doc/BRIEF.md
# Evaluation Stack Arithmetic Unit

This block is a small hardware evaluation stack with an ALU attached. Instructions arrive as a bare operation code on a valid/ready handshake, together with a memory address that only the load and store operations use. Arithmetic instructions never name operands. They always take the topmost stack entries. Binary operations consume two entries and leave one result. Negation rewrites the top entry in place.

A load fetches a word through a simple read-request port and places it on top of the stack. A store removes the top word and sends it out through a write port. The stack depth is visible at all times. Sticky flags record an overflow or underflow attempt, and two live status bits describe the current top entry.

Top module: `evstack_unit`

## Requirements
- R1: After reset, depth is 0, all four flags are 0, op_ready is 1, and rd_req and wr_en are 0.
- R2: Code 0 (PUSH), accepted with depth below 16, raises rd_req with rd_addr equal to op_addr from the next cycle. rd_req stays high until rd_valid is seen, and op_ready stays low over the same span. The rd_data word sampled with rd_valid becomes the new top, and depth grows by one.
- R3: Code 1 (POP), accepted with depth at least 1, drives wr_en high for exactly one cycle, starting the cycle after acceptance. In that cycle wr_addr equals op_addr and wr_data equals the old top, and depth drops by one.
- R4: Codes 2 (ADD), 3 (SUB), 4 (AND) and 5 (OR), with depth at least 2, replace the two top entries with one result, so depth drops by one. SUB computes second-from-top minus top, modulo 2^16.
- R5: Code 6 (NEG), with depth at least 1, replaces the top entry with its two's-complement negation modulo 2^16 and leaves depth unchanged. Negating 0x8000 yields 0x8000.
- R6: A binary code with fewer than two entries, or POP or NEG on an empty stack, sets flag_unf. The flag then stays set until reset, and neither the stack nor wr_en changes.
- R7: PUSH with depth equal to 16 sets flag_ovf, which then stays set until reset. The push is discarded: no read request is made and depth stays at 16.
- R8: When depth is 0, flag_zero and flag_neg are both 0. Otherwise flag_zero is 1 exactly when the top entry is 0, and flag_neg equals bit 15 of the top entry.
- R9: Code 7 is accepted and changes neither depth, flags nor the memory ports.
- R10: Depth never exceeds 16. Sixteen pushes followed by sixteen pops return the words in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation this cycle |
| op_code | input | 3 | Operation code (0 PUSH, 1 POP, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 NEG, 7 no effect) |
| op_addr | input | 8 | Memory address for PUSH and POP |
| rd_req | output | 1 | Read request, held until data returns |
| rd_addr | output | 8 | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data word |
| wr_en | output | 1 | Write strobe, one cycle per POP |
| wr_addr | output | 8 | Write address |
| wr_data | output | 16 | Write data word |
| depth | output | 5 | Number of stack entries |
| flag_ovf | output | 1 | Sticky overflow |
| flag_unf | output | 1 | Sticky underflow |
| flag_zero | output | 1 | Top entry is zero |
| flag_neg | output | 1 | Top entry is negative |

## Verification
The arithmetic is exercised with operand pairs that give a positive difference, a negative difference and a zero result. This separates the order of the SUB operands and shows the sign and zero bits following the new top. Negation is tried on an ordinary word and on 0x8000, which tells a true two's-complement wrap from a saturating one. Underflow is provoked by each offending kind of operation at depths 0 and 1, and overflow is provoked by a seventeenth push. A full fill-and-drain with a different read latency on each push checks LIFO ordering and shows the stall on PUSH tracking the read latency.

// File: rtl/evstack_pkg.sv
package evstack_pkg;

  typedef enum logic [2:0] {
    OPC_PUSH = 3'd0,
    OPC_POP  = 3'd1,
    OPC_ADD  = 3'd2,
    OPC_SUB  = 3'd3,
    OPC_AND  = 3'd4,
    OPC_OR   = 3'd5,
    OPC_NEG  = 3'd6,
    OPC_NONE = 3'd7
  } opc_e;

  typedef enum logic {
    ST_READY = 1'b0,
    ST_FETCH = 1'b1
  } st_e;

  function automatic logic opc_binary(input opc_e op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_AND) || (op == OPC_OR);
  endfunction

endpackage

// File: rtl/evstack_alu.sv
module evstack_alu
  import evstack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opc_e              op,
  input  logic [DATA_W-1:0] below,
  input  logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] res
);

  function automatic logic [DATA_W-1:0] calc(input opc_e o,
                                             input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    case (o)
      OPC_ADD: return a + b;
      OPC_SUB: return a - b;
      OPC_AND: return a & b;
      OPC_OR:  return a | b;
      OPC_NEG: return '0 - b;
      default: return b;
    endcase
  endfunction

  always_comb res = calc(op, below, top);

endmodule

// File: rtl/evstack_store.sv
module evstack_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] below
);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(g))) slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  logic [CNT_W-1:0] i_top, i_below;
  always_comb begin
    i_top   = cnt - CNT_W'(1);
    i_below = cnt - CNT_W'(2);
    top     = (cnt >= CNT_W'(1)) ? slot[IDX_W'(i_top)]   : '0;
    below   = (cnt >= CNT_W'(2)) ? slot[IDX_W'(i_below)] : '0;
  end

endmodule

// File: rtl/evstack_unit.sv
module evstack_unit
  import evstack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  depth,
  output logic              flag_ovf,
  output logic              flag_unf,
  output logic              flag_zero,
  output logic              flag_neg
);

  st_e               st;
  opc_e              opc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] top_q, below_q, alu_res;
  logic              st_we;
  logic [IDX_W-1:0]  st_widx;
  logic [DATA_W-1:0] st_wdata;

  assign opc      = opc_e'(op_code);
  assign op_ready = (st == ST_READY);
  assign rd_req   = (st == ST_FETCH);
  assign depth    = cnt_q;

  // Named events, also observed by the bound checker
  logic accept, is_full, has1, has2;
  logic ev_fetch, ev_fill, ev_pop, ev_bin, ev_neg, ev_ovf, ev_unf;

  assign accept   = op_valid && op_ready;
  assign is_full  = (cnt_q == CNT_W'(DEPTH));
  assign has1     = (cnt_q >= CNT_W'(1));
  assign has2     = (cnt_q >= CNT_W'(2));
  assign ev_fetch = accept && (opc == OPC_PUSH) && !is_full;
  assign ev_ovf   = accept && (opc == OPC_PUSH) && is_full;
  assign ev_fill  = (st == ST_FETCH) && rd_valid;
  assign ev_pop   = accept && (opc == OPC_POP) && has1;
  assign ev_bin   = accept && opc_binary(opc) && has2;
  assign ev_neg   = accept && (opc == OPC_NEG) && has1;
  assign ev_unf   = accept && ((opc_binary(opc) && !has2) ||
                               (((opc == OPC_POP) || (opc == OPC_NEG)) && !has1));

  evstack_alu #(.DATA_W(DATA_W)) u_alu (
    .op(opc), .below(below_q), .top(top_q), .res(alu_res)
  );

  evstack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .widx(st_widx), .wdata(st_wdata),
    .cnt_d(cnt_d), .cnt(cnt_q), .top(top_q), .below(below_q)
  );

  always_comb begin
    st_we    = 1'b0;
    st_widx  = '0;
    st_wdata = alu_res;
    cnt_d    = cnt_q;
    if (ev_fill) begin
      st_we    = 1'b1;
      st_widx  = IDX_W'(cnt_q);
      st_wdata = rd_data;
      cnt_d    = cnt_q + CNT_W'(1);
    end else if (ev_bin) begin
      st_we   = 1'b1;
      st_widx = IDX_W'(cnt_q - CNT_W'(2));
      cnt_d   = cnt_q - CNT_W'(1);
    end else if (ev_neg) begin
      st_we   = 1'b1;
      st_widx = IDX_W'(cnt_q - CNT_W'(1));
    end else if (ev_pop) begin
      cnt_d   = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_READY;
      rd_addr  <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      flag_ovf <= 1'b0;
      flag_unf <= 1'b0;
    end else begin
      wr_en <= ev_pop;
      if (ev_pop) begin
        wr_addr <= op_addr;
        wr_data <= top_q;
      end
      if (ev_fetch) begin
        st      <= ST_FETCH;
        rd_addr <= op_addr;
      end else if (ev_fill) begin
        st <= ST_READY;
      end
      if (ev_ovf) flag_ovf <= 1'b1;
      if (ev_unf) flag_unf <= 1'b1;
    end
  end

  assign flag_zero = has1 && (top_q == '0);
  assign flag_neg  = has1 && top_q[DATA_W-1];

endmodule

// File: rtl/evstack_unit_chk.sv
module evstack_unit_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              rd_req,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  depth,
  input logic              flag_ovf,
  input logic              flag_unf,
  input logic              flag_zero,
  input logic [DATA_W-1:0] top_q,
  input logic              ev_fill,
  input logic              ev_pop,
  input logic              ev_bin,
  input logic              ev_neg,
  input logic              ev_ovf,
  input logic              ev_unf
);

  assert_fetch_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !op_ready);

  assert_fill_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> depth == $past(depth) + CNT_W'(1));

  assert_pop_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> wr_en && (wr_data == $past(top_q)) && (depth == $past(depth) - CNT_W'(1)));

  assert_write_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ev_pop));

  assert_bin_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bin |=> depth == $past(depth) - CNT_W'(1));

  assert_neg_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_neg |=> $stable(depth));

  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> flag_unf && $stable(depth) && !wr_en);

  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_unf |=> flag_unf);

  assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> flag_ovf && $stable(depth) && !rd_req);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |=> flag_ovf);

  assert_zero_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero |-> (depth != '0));

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

endmodule

bind evstack_unit evstack_unit_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .rd_req(rd_req),
  .wr_en(wr_en), .wr_data(wr_data), .depth(depth),
  .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_zero(flag_zero),
  .top_q(top_q), .ev_fill(ev_fill), .ev_pop(ev_pop), .ev_bin(ev_bin),
  .ev_neg(ev_neg), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
);

// File: tb/evstack_unit_tb.sv
module evstack_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_code = 3'd7;
  logic [7:0]  op_addr = '0;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic [4:0]  depth;
  logic        flag_ovf, flag_unf, flag_zero, flag_neg;

  always #2 clk = ~clk;

  evstack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_addr(op_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .depth(depth), .flag_ovf(flag_ovf), .flag_unf(flag_unf),
    .flag_zero(flag_zero), .flag_neg(flag_neg)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mem_img [256];
  logic [15:0] mdl [$];
  logic [23:0] exp_wr [$];
  logic m_ovf = 1'b0;
  logic m_unf = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder with a latency that changes per request
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        repeat (lat) @(negedge clk);
        rd_data  = mem_img[rd_addr];
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        lat = (lat + 1) % 4;
      end
    end
  end

  // Scoreboard monitor for the write port
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_wr.size() == 0) chk("R3 unexpected write", {8'h0, wr_addr, wr_data}, 32'hFFFF_FFFF);
      else chk("R3 R10 pop write", {8'h0, wr_addr, wr_data}, {8'h0, exp_wr.pop_front()});
    end
  end

  task automatic check_state(input string req);
    logic [15:0] t;
    int n = mdl.size();
    t = (n > 0) ? mdl[n-1] : 16'h0;
    chk({req, " depth"}, 32'(depth), 32'(n));
    chk({req, " R8 zero"}, 32'(flag_zero), 32'((n > 0) && (t == 16'h0)));
    chk({req, " R8 neg"}, 32'(flag_neg), 32'((n > 0) && t[15]));
    chk({req, " R6 unf"}, 32'(flag_unf), 32'(m_unf));
    chk({req, " R7 ovf"}, 32'(flag_ovf), 32'(m_ovf));
  endtask

  task automatic do_op(input logic [2:0] code, input logic [7:0] addr, input string req);
    logic [15:0] a, b, r;
    int n = mdl.size();
    logic fetch = 1'b0;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_addr = addr;
    case (code)
      3'd0: if (n == 16) m_ovf = 1'b1; else fetch = 1'b1;
      3'd1: if (n == 0) m_unf = 1'b1;
            else begin exp_wr.push_back({addr, mdl[n-1]}); void'(mdl.pop_back()); end
      3'd2, 3'd3, 3'd4, 3'd5:
            if (n < 2) m_unf = 1'b1;
            else begin
              b = mdl.pop_back(); a = mdl.pop_back();
              if (code == 3'd2) r = a + b;
              else if (code == 3'd3) r = a + (~b + 16'h1);
              else if (code == 3'd4) r = a & b;
              else r = a | b;
              mdl.push_back(r);
            end
      3'd6: if (n == 0) m_unf = 1'b1; else mdl[n-1] = ~mdl[n-1] + 16'h1;
      default: ;
    endcase
    while (!op_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd7;
    if (fetch) begin
      chk("R2 request", {22'h0, rd_req, op_ready, rd_addr}, {22'h0, 1'b1, 1'b0, addr});
      while (!op_ready) @(negedge clk);
      mdl.push_back(mem_img[addr]);
    end else if (code == 3'd0) begin
      chk("R7 no request", 32'(rd_req), 32'h0);
    end
    check_state(req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_img[i] = 16'(i * 97 + 13);
    mem_img[10] = 16'h0000;
    mem_img[11] = 16'h8000;
    mem_img[12] = 16'h7FFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 depth", 32'(depth), 32'h0);
    chk("R1 flags", {28'h0, flag_ovf, flag_unf, flag_zero, flag_neg}, 32'h0);
    chk("R1 ports", {29'h0, op_ready, rd_req, wr_en}, 32'h4);
    rst_n = 1'b1;

    do_op(3'd0, 8'd1, "R2");
    do_op(3'd0, 8'd2, "R2");
    do_op(3'd2, 8'd0, "R4 add");
    do_op(3'd0, 8'd3, "R2");
    do_op(3'd3, 8'd0, "R4 sub positive");
    do_op(3'd0, 8'd12, "R2");
    do_op(3'd3, 8'd0, "R4 sub negative");
    do_op(3'd0, 8'd10, "R8 zero top");
    do_op(3'd5, 8'd0, "R4 or");
    do_op(3'd0, 8'd4, "R2");
    do_op(3'd4, 8'd0, "R4 and");
    do_op(3'd0, 8'd7, "R2");
    do_op(3'd0, 8'd7, "R2");
    do_op(3'd3, 8'd0, "R4 sub zero");
    do_op(3'd6, 8'd0, "R5 neg zero");
    do_op(3'd0, 8'd9, "R2");
    do_op(3'd6, 8'd0, "R5 neg");
    do_op(3'd0, 8'd11, "R2");
    do_op(3'd6, 8'd0, "R5 neg min");
    chk("R5 min value", 32'(mdl[mdl.size()-1]), 32'h8000);
    do_op(3'd7, 8'd0, "R9 no effect");
    while (mdl.size() > 0) do_op(3'd1, 8'(8'h40 + mdl.size()), "R3 pop");
    // underflow cases
    do_op(3'd1, 8'h50, "R6 pop empty");
    do_op(3'd6, 8'h00, "R6 neg empty");
    do_op(3'd0, 8'd5, "R2");
    do_op(3'd2, 8'h00, "R6 add one entry");
    do_op(3'd3, 8'h00, "R6 sub one entry");
    do_op(3'd1, 8'h51, "R3 pop");
    // fill, overflow, drain
    for (int i = 0; i < 16; i++) do_op(3'd0, 8'(20 + i), "R10 fill");
    do_op(3'd0, 8'd40, "R7 push full");
    do_op(3'd7, 8'd0, "R9 no effect full");
    for (int i = 0; i < 16; i++) do_op(3'd1, 8'(8'h80 + i), "R10 drain");
    repeat (2) @(negedge clk);
    chk("R3 all writes seen", 32'(exp_wr.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule